// File: doc/BRIEF.md
# Modular Exponentiation Core Host Interface

This block is the bus-facing front end of a modular multiplication and exponentiation engine. It is an AXI4-Lite slave with a 32-bit data path. The slave answers only inside a window whose upper address bits match a base address. Within that window it decodes one control and status register, and it passes full-word writes through to an operand/modulus RAM port. The engine's datapath, its FIFO and the RAM itself sit outside this block.

Software uses the control register to pick the active pipeline part, choose the operands for a single multiplication and select single-multiply or exponentiation mode. It also issues a one-cycle start pulse or a one-cycle soft reset through the same register. The engine reports four events as single-cycle pulses: operation done, memory collision, FIFO full and FIFO push error. Each event latches a sticky flag that stays set until software clears it. While any flag is set, a level interrupt is held high.

Top module: `mexp_host_if`

## Requirements
- R1: An access is taken only when address bits 31:15 equal bits 31:15 of `BASE_ADDR`. Any other write is answered OKAY and changes neither the register nor the RAM port. Any other read returns zero with OKAY.
- R2: The control register sits at window offset 0x6000. Its fields are: bits 31:30 pipeline-part select (01 lower, 10 upper, 11 full, 00 invalid), bits 29:28 destination operand, bits 27:26 x operand, bits 25:24 y operand, and bit 22 mode (0 single multiply, 1 exponentiation). The written fields read back and drive `pipe_sel_o`, `dst_op_o`, `x_op_o`, `y_op_o` and `exp_mode_o` from the cycle after the write handshake.
- R3: Register bits 23, 21, 20, 19:16 and 11:0 always read as zero.
- R4: Writing 1 to bit 23 makes `start_o` high for exactly the one cycle after the write handshake. The same write clears all four flags.
- R5: Writing 1 to bit 20 clears every field and flag, whatever the other written bits are. It makes `core_rst_o` high for exactly one cycle, and no start pulse is issued.
- R6: `ev_i` bit 3 (done), bit 2 (collision), bit 1 (FIFO full) and bit 0 (push error) set register bits 15, 14, 13 and 12 respectively. A flag stays set across any later cycles, and writing 1 to it has no effect.
- R7: Writing 0 to a flag bit clears that flag. If the flag's event arrives in the same cycle as a clear by a write or a start, the flag ends up set.
- R8: `irq_o` is high exactly while at least one flag is set, and it goes high in the cycle after the setting event.
- R9: A write at window offset 0x0000 to 0x5FFF with `s_wstrb` = 4'b1111 pulses `ram_we_o` for one cycle. `ram_waddr_o` is set to offset bits 14:2 and `ram_wdata_o` to the data, and the response is OKAY. With any other strobe the write is dropped and answered with SLVERR (2'b10).
- R10: In a control-register write, only byte lanes with a set strobe take effect. Lane 3 carries the operand and part fields, lane 2 carries start, mode and soft reset, and lane 1 carries the flag clears.
- R11: Each channel has at most one transaction outstanding. `s_bvalid` and `s_rvalid` with their response and data stay stable until the ready input is taken. Reads of the RAM window or of unused offsets return zero with OKAY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awaddr | input | 32 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 32 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| ev_i | input | 4 | Event pulses from the engine (3 done, 2 collision, 1 FIFO full, 0 push error) |
| pipe_sel_o | output | 2 | Active pipeline part |
| dst_op_o | output | 2 | Destination operand index |
| x_op_o | output | 2 | x operand index |
| y_op_o | output | 2 | y operand index |
| exp_mode_o | output | 1 | 1 selects exponentiation mode |
| start_o | output | 1 | One-cycle start pulse |
| core_rst_o | output | 1 | One-cycle soft reset to the engine |
| irq_o | output | 1 | Level interrupt |
| ram_we_o | output | 1 | RAM word write enable |
| ram_waddr_o | output | 13 | RAM word address |
| ram_wdata_o | output | 32 | RAM write data |

## Verification
A corrupted field or flag shows up on the dedicated control outputs and on `irq_o` in the first cycle after the faulty edge. It also shows in the next register read, which returns data two edges after the read address is presented. A write-channel state held wrongly shows as a missing or repeated `s_bvalid`, a wrong response code, or a `ram_we_o` pulse where none is due, all in the cycle after the handshake. Event and clear collisions are driven on the exact handshake edge, so a priority error gives a wrong flag on the very next read.

// File: rtl/mexp_host_pkg.sv
// Shared constants and helpers for the exponentiation-core host interface.
// Assumes a 32-bit AXI4-Lite data path and a 15-bit offset space per window.
package mexp_host_pkg;

    localparam int unsigned WIN_BITS  = 15;
    localparam int unsigned NFLAG     = 4;
    localparam logic [WIN_BITS-1:0] CTRL_OFS  = 15'h6000;
    localparam logic [WIN_BITS-1:0] RAM_LIMIT = 15'h6000;

    localparam int unsigned B_PSEL  = 30;
    localparam int unsigned B_DST   = 28;
    localparam int unsigned B_XOP   = 26;
    localparam int unsigned B_YOP   = 24;
    localparam int unsigned B_START = 23;
    localparam int unsigned B_MODE  = 22;
    localparam int unsigned B_SRST  = 20;
    localparam int unsigned B_FLAG  = 12;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;

    typedef struct packed {
        logic [1:0] psel;
        logic [1:0] dst;
        logic [1:0] xop;
        logic [1:0] yop;
        logic       mode;
    } ctrl_fields_t;

    // True when the upper address bits select this block's window
    function automatic logic win_hit(input logic [31:0] addr, input logic [31:0] base);
        return addr[31:WIN_BITS] == base[31:WIN_BITS];
    endfunction

endpackage

// File: rtl/mexp_wr_port.sv
// Write channel of the host interface: joins AW and W into one handshake,
// decodes the target, forwards full-word RAM writes and returns BRESP.
// Assumes one outstanding write; a new write is refused while BVALID is high.
module mexp_wr_port
    import mexp_host_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DATA_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'h4000_0000,
    localparam int unsigned STRB_W   = DATA_W / 8,
    localparam int unsigned RAM_AW   = WIN_BITS - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  awaddr,
    input  logic               awvalid,
    output logic               awready,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [STRB_W-1:0]  wstrb,
    input  logic               wvalid,
    output logic               wready,
    output logic [1:0]         bresp,
    output logic               bvalid,
    input  logic               bready,
    output logic               ctrl_wr,
    output logic               ram_we,
    output logic [RAM_AW-1:0]  ram_waddr,
    output logic [DATA_W-1:0]  ram_wdata
);

    logic                bvalid_q;
    logic [1:0]          bresp_q;
    logic                hs;
    logic                hit;
    logic                in_ram;
    logic                full_word;
    logic [WIN_BITS-1:0] ofs;

    // Accept address and data together, only when no response is pending
    always_comb begin
        awready   = wvalid && !bvalid_q;
        wready    = awvalid && !bvalid_q;
        hs        = awvalid && wvalid && !bvalid_q;
        ofs       = awaddr[WIN_BITS-1:0];
        hit       = win_hit(awaddr, BASE_ADDR);
        in_ram    = hit && (ofs < RAM_LIMIT);
        full_word = &wstrb;
        ctrl_wr   = hs && hit && (ofs[WIN_BITS-1:2] == CTRL_OFS[WIN_BITS-1:2]);
    end

    // Response register: set on handshake, held until the master takes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bvalid_q <= 1'b0;
            bresp_q  <= RESP_OKAY;
        end else if (hs) begin
            bvalid_q <= 1'b1;
            bresp_q  <= (in_ram && !full_word) ? RESP_SLVERR : RESP_OKAY;
        end else if (bready) begin
            bvalid_q <= 1'b0;
        end
    end

    // RAM write port: one-cycle enable for full-word writes into the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we    <= 1'b0;
            ram_waddr <= '0;
            ram_wdata <= '0;
        end else begin
            ram_we <= hs && in_ram && full_word;
            if (hs && in_ram && full_word) begin
                ram_waddr <= ofs[WIN_BITS-1:2];
                ram_wdata <= wdata;
            end
        end
    end

    assign bvalid = bvalid_q;
    assign bresp  = bresp_q;

endmodule

// File: rtl/mexp_rd_port.sv
// Read channel of the host interface: returns the control register at its
// offset and zero elsewhere. Assumes one outstanding read at a time.
module mexp_rd_port
    import mexp_host_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DATA_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'h4000_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  araddr,
    input  logic               arvalid,
    output logic               arready,
    output logic [DATA_W-1:0]  rdata,
    output logic [1:0]         rresp,
    output logic               rvalid,
    input  logic               rready,
    input  logic [DATA_W-1:0]  ctrl_value
);

    logic              rvalid_q;
    logic [DATA_W-1:0] rdata_q;
    logic              is_ctrl;

    // Address decode for the single readable register
    always_comb begin
        is_ctrl = win_hit(araddr, BASE_ADDR)
               && (araddr[WIN_BITS-1:2] == CTRL_OFS[WIN_BITS-1:2]);
        arready = !rvalid_q;
    end

    // Read data register: loaded on handshake, held until RREADY
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else if (arvalid && !rvalid_q) begin
            rvalid_q <= 1'b1;
            rdata_q  <= is_ctrl ? ctrl_value : '0;
        end else if (rready) begin
            rvalid_q <= 1'b0;
        end
    end

    assign rvalid = rvalid_q;
    assign rdata  = rdata_q;
    assign rresp  = RESP_OKAY;

endmodule

// File: rtl/mexp_ctrl_file.sv
// Control/status register: operand and mode fields, self-clearing start and
// soft-reset bits, and sticky event flags feeding a level interrupt.
// Assumes events are single-cycle pulses; an event beats any same-cycle clear
// except a soft reset.
module mexp_ctrl_file
    import mexp_host_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned STRB_W = DATA_W / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [STRB_W-1:0]  wstrb,
    input  logic [NFLAG-1:0]   ev,
    output ctrl_fields_t       fields,
    output logic               start_p,
    output logic               srst_p,
    output logic               irq,
    output logic [DATA_W-1:0]  rd_value
);

    ctrl_fields_t     fields_q;
    logic [NFLAG-1:0] flags_q;
    logic             srst_req;
    logic             start_req;
    logic             lane_hi;
    logic             lane_cmd;
    logic             lane_flag;

    // Decode the command bits of the current write
    always_comb begin
        lane_hi   = wr_en && wstrb[B_PSEL/8];
        lane_cmd  = wr_en && wstrb[B_START/8];
        lane_flag = wr_en && wstrb[B_FLAG/8];
        srst_req  = lane_cmd && wdata[B_SRST];
        start_req = lane_cmd && wdata[B_START] && !srst_req;
    end

    // Field storage, byte-lane gated, cleared by soft reset
    always_ff @(posedge clk) begin
        if (!rst_n || srst_req) begin
            fields_q <= '0;
        end else begin
            if (lane_hi) begin
                fields_q.psel <= wdata[B_PSEL+1:B_PSEL];
                fields_q.dst  <= wdata[B_DST+1:B_DST];
                fields_q.xop  <= wdata[B_XOP+1:B_XOP];
                fields_q.yop  <= wdata[B_YOP+1:B_YOP];
            end
            if (lane_cmd) begin
                fields_q.mode <= wdata[B_MODE];
            end
        end
    end

    // One-cycle command pulses to the engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_p <= 1'b0;
            srst_p  <= 1'b0;
        end else begin
            start_p <= start_req;
            srst_p  <= srst_req;
        end
    end

    // Sticky flags, one per event line
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n || srst_req) begin
                flags_q[i] <= 1'b0;
            end else if (ev[i]) begin
                flags_q[i] <= 1'b1;
            end else if (start_req || (lane_flag && !wdata[B_FLAG+i])) begin
                flags_q[i] <= 1'b0;
            end
        end
    end

    // Readback image; unimplemented and self-clearing bits read as zero
    always_comb begin
        rd_value                      = '0;
        rd_value[B_PSEL+1:B_PSEL]     = fields_q.psel;
        rd_value[B_DST+1:B_DST]       = fields_q.dst;
        rd_value[B_XOP+1:B_XOP]       = fields_q.xop;
        rd_value[B_YOP+1:B_YOP]       = fields_q.yop;
        rd_value[B_MODE]              = fields_q.mode;
        rd_value[B_FLAG+NFLAG-1:B_FLAG] = flags_q;
    end

    assign fields = fields_q;
    assign irq    = |flags_q;

endmodule

// File: rtl/mexp_host_if.sv
// Top of the exponentiation-core host interface: AXI4-Lite slave, control
// register and operand RAM write window. Assumes BASE_ADDR[14:0] is zero.
module mexp_host_if
    import mexp_host_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DATA_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'h4000_0000,
    localparam int unsigned STRB_W   = DATA_W / 8,
    localparam int unsigned RAM_AW   = WIN_BITS - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  s_awaddr,
    input  logic               s_awvalid,
    output logic               s_awready,
    input  logic [DATA_W-1:0]  s_wdata,
    input  logic [STRB_W-1:0]  s_wstrb,
    input  logic               s_wvalid,
    output logic               s_wready,
    output logic [1:0]         s_bresp,
    output logic               s_bvalid,
    input  logic               s_bready,
    input  logic [ADDR_W-1:0]  s_araddr,
    input  logic               s_arvalid,
    output logic               s_arready,
    output logic [DATA_W-1:0]  s_rdata,
    output logic [1:0]         s_rresp,
    output logic               s_rvalid,
    input  logic               s_rready,
    input  logic [NFLAG-1:0]   ev_i,
    output logic [1:0]         pipe_sel_o,
    output logic [1:0]         dst_op_o,
    output logic [1:0]         x_op_o,
    output logic [1:0]         y_op_o,
    output logic               exp_mode_o,
    output logic               start_o,
    output logic               core_rst_o,
    output logic               irq_o,
    output logic               ram_we_o,
    output logic [RAM_AW-1:0]  ram_waddr_o,
    output logic [DATA_W-1:0]  ram_wdata_o
);

    logic              ctrl_wr;
    logic [DATA_W-1:0] ctrl_value;
    ctrl_fields_t      fields;

    mexp_wr_port #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)
    ) u_wr (
        .clk(clk), .rst_n(rst_n),
        .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
        .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
        .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
        .ctrl_wr(ctrl_wr),
        .ram_we(ram_we_o), .ram_waddr(ram_waddr_o), .ram_wdata(ram_wdata_o)
    );

    mexp_rd_port #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)
    ) u_rd (
        .clk(clk), .rst_n(rst_n),
        .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
        .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
        .ctrl_value(ctrl_value)
    );

    mexp_ctrl_file #(
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ctrl_wr), .wdata(s_wdata), .wstrb(s_wstrb), .ev(ev_i),
        .fields(fields), .start_p(start_o), .srst_p(core_rst_o),
        .irq(irq_o), .rd_value(ctrl_value)
    );

    // Fan the stored fields out to the engine control pins
    always_comb begin
        pipe_sel_o = fields.psel;
        dst_op_o   = fields.dst;
        x_op_o     = fields.xop;
        y_op_o     = fields.yop;
        exp_mode_o = fields.mode;
    end

endmodule

// File: rtl/mexp_host_if_chk.sv
// Protocol and register-behaviour checker for mexp_host_if, bound to the top.
module mexp_host_if_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] ev_i,
    input logic       ctrl_wr,
    input logic [3:0] s_wstrb,
    input logic       s_wdata_srst,
    input logic       s_bvalid,
    input logic       s_bready,
    input logic [1:0] s_bresp,
    input logic       s_rvalid,
    input logic       s_rready,
    input logic [31:0] s_rdata,
    input logic       start_o,
    input logic       core_rst_o,
    input logic       irq_o,
    input logic [1:0] pipe_sel_o,
    input logic       exp_mode_o,
    input logic       ram_we_o
);

    // R4
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // R5
    srst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_o |=> !core_rst_o);

    // R5
    srst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_o |-> (!irq_o && pipe_sel_o == 2'b00 && !exp_mode_o && !start_o));

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_i && !(ctrl_wr && s_wstrb[2] && s_wdata_srst)) |=> irq_o);

    // R6
    irq_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && ev_i == 4'b0000) |=> !irq_o);

    // R11
    b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp)));

    // R11
    r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));

    // R9
    ram_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> (s_bvalid && s_bresp == 2'b00));

endmodule

bind mexp_host_if mexp_host_if_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .ctrl_wr(ctrl_wr),
    .s_wstrb(s_wstrb), .s_wdata_srst(s_wdata[20]),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
    .start_o(start_o), .core_rst_o(core_rst_o), .irq_o(irq_o),
    .pipe_sel_o(pipe_sel_o), .exp_mode_o(exp_mode_o), .ram_we_o(ram_we_o)
);

// File: tb/test_mexp_host_if.sv
// Bench: directed corners plus seeded random traffic against a register model.
module test_mexp_host_if;

    localparam logic [31:0] BASE = 32'h4000_0000;
    localparam logic [31:0] CTRL = BASE + 32'h6000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] s_awaddr = '0, s_wdata = '0, s_araddr = '0;
    logic [3:0]  s_wstrb = '0, ev_i = '0;
    logic        s_awvalid = 1'b0, s_wvalid = 1'b0, s_bready = 1'b1;
    logic        s_arvalid = 1'b0, s_rready = 1'b1;
    logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0]  s_bresp, s_rresp;
    logic [31:0] s_rdata;
    logic [1:0]  pipe_sel_o, dst_op_o, x_op_o, y_op_o;
    logic        exp_mode_o, start_o, core_rst_o, irq_o, ram_we_o;
    logic [12:0] ram_waddr_o;
    logic [31:0] ram_wdata_o;

    int unsigned n_cmp = 0, n_bad = 0;
    bit          finished = 1'b0;
    logic [31:0] mdl = '0;

    // snapshots taken by the bus tasks
    logic [1:0]  g_bresp;
    logic        g_bvalid, g_start, g_crst, g_we, g_start2, g_crst2, g_we2;
    logic [12:0] g_waddr;
    logic [31:0] g_wdata, g_rdata;
    logic [1:0]  g_rresp;

    always #2 clk = ~clk;

    mexp_host_if #(.BASE_ADDR(BASE)) i_mexp_host_if (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Register model: next value after a control write (wr) and events (ev)
    function automatic logic [31:0] mdl_next(input logic [31:0] cur, input bit wr,
                                             input logic [31:0] wd, input logic [3:0] st,
                                             input logic [3:0] ev);
        logic [31:0] n;
        logic [3:0]  clr;
        n   = cur;
        clr = 4'h0;
        if (wr && st[2] && wd[20]) return 32'h0;
        if (wr && st[3]) n[31:24] = wd[31:24];
        if (wr && st[2]) n[22] = wd[22];
        if (wr && st[2] && wd[23]) clr = 4'hF;
        else if (wr && st[1]) clr = ~wd[15:12];
        n[15:12] = (cur[15:12] & ~clr) | ev;
        return n;
    endfunction

    function automatic logic [1:0] exp_bresp(input logic [31:0] a, input logic [3:0] st);
        if (a[31:15] == BASE[31:15] && a[14:0] < 15'h6000 && st != 4'hF) return 2'b10;
        return 2'b00;
    endfunction

    task automatic axi_write(input logic [31:0] a, input logic [31:0] d,
                             input logic [3:0] st, input logic [3:0] ev);
        @(negedge clk);
        s_awaddr = a; s_wdata = d; s_wstrb = st; ev_i = ev;
        s_awvalid = 1'b1; s_wvalid = 1'b1;
        @(posedge clk);
        #1;
        s_awvalid = 1'b0; s_wvalid = 1'b0; ev_i = 4'h0;
        @(negedge clk);
        g_bvalid = s_bvalid; g_bresp = s_bresp; g_start = start_o; g_crst = core_rst_o;
        g_we = ram_we_o; g_waddr = ram_waddr_o; g_wdata = ram_wdata_o;
        @(negedge clk);
        g_start2 = start_o; g_crst2 = core_rst_o; g_we2 = ram_we_o;
        mdl = mdl_next(mdl, (a[31:2] == CTRL[31:2]), d, st, ev);
    endtask

    task automatic axi_read(input logic [31:0] a);
        @(negedge clk);
        s_araddr = a; s_arvalid = 1'b1;
        @(posedge clk);
        #1;
        s_arvalid = 1'b0;
        @(negedge clk);
        check("R11 rvalid", {31'b0, s_rvalid}, 32'h1);
        g_rdata = s_rdata; g_rresp = s_rresp;
    endtask

    task automatic pulse_ev(input logic [3:0] ev);
        @(negedge clk);
        ev_i = ev;
        @(posedge clk);
        #1;
        ev_i = 4'h0;
        mdl = mdl_next(mdl, 1'b0, 32'h0, 4'h0, ev);
        @(negedge clk);
        check("R8 irq level", {31'b0, irq_o}, {31'b0, |mdl[15:12]});
    endtask

    task automatic check_ctrl(input string req);
        axi_read(CTRL);
        check(req, g_rdata, mdl);
        check("R2 pins", {23'b0, pipe_sel_o, dst_op_o, x_op_o, y_op_o, exp_mode_o},
              {23'b0, mdl[31:24], mdl[22]});
        check("R8 irq", {31'b0, irq_o}, {31'b0, |mdl[15:12]});
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, d;
        logic [3:0]  st, ev;
        int unsigned op;
        void'($urandom(32'd1234));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        check_ctrl("R2 reset value");

        // R2 / R3 / R4: write all ones except soft reset
        axi_write(CTRL, 32'hFFEF_FFFF, 4'hF, 4'h0);
        check("R4 start pulse", {31'b0, g_start}, 32'h1);
        check("R4 start single", {31'b0, g_start2}, 32'h0);
        check_ctrl("R3 unimplemented zero");

        // R6: events set flags, writing ones leaves them
        pulse_ev(4'b1010);
        axi_write(CTRL, 32'h5A00_F000, 4'hF, 4'h0);
        check_ctrl("R6 sticky under write-one");

        // R7: clear one flag, then collision with clear
        axi_write(CTRL, 32'h5A00_7000, 4'hF, 4'h0);
        check_ctrl("R7 software clear");
        pulse_ev(4'b0101);
        axi_write(CTRL, 32'h5A00_0000, 4'hF, 4'b1000);
        check_ctrl("R7 set beats clear");

        // R4: start clears flags, event in same cycle survives
        pulse_ev(4'b0111);
        axi_write(CTRL, 32'h5A80_0000, 4'hF, 4'b0001);
        check_ctrl("R4 start clears flags");

        // R10: only lane 0 strobe -> nothing; lane 3 only -> fields only
        axi_write(CTRL, 32'h0000_0000, 4'b0001, 4'h0);
        check_ctrl("R10 lane0 ignored");
        axi_write(CTRL, 32'h81D0_0000, 4'b1000, 4'h0);
        check("R10 no start via masked lane", {31'b0, g_start}, 32'h0);
        check_ctrl("R10 lane3 only");

        // R5: soft reset with start and fields
        pulse_ev(4'b1111);
        axi_write(CTRL, 32'hFFD0_0000, 4'hF, 4'h0);
        check("R5 core reset pulse", {30'b0, g_crst, g_start}, 32'h2);
        check("R5 core reset single", {31'b0, g_crst2}, 32'h0);
        check_ctrl("R5 all cleared");

        // R9: RAM window
        axi_write(BASE + 32'h10, 32'hDEAD_BEEF, 4'hF, 4'h0);
        check("R9 we", {31'b0, g_we}, 32'h1);
        check("R9 we single", {31'b0, g_we2}, 32'h0);
        check("R9 waddr", {19'b0, g_waddr}, 32'h4);
        check("R9 wdata", g_wdata, 32'hDEAD_BEEF);
        check("R9 okay", {30'b0, g_bresp}, 32'h0);
        axi_write(BASE + 32'h5FFC, 32'h1234_5678, 4'hF, 4'h0);
        check("R9 last word addr", {19'b0, g_waddr}, 32'h17FF);
        axi_write(BASE + 32'h20, 32'h1111_1111, 4'b0111, 4'h0);
        check("R9 partial dropped", {31'b0, g_we}, 32'h0);
        check("R9 slverr", {30'b0, g_bresp}, 32'h2);

        // R1: other window
        axi_write((BASE ^ 32'h0001_0000) + 32'h6000, 32'hC000_0000, 4'hF, 4'h0);
        check("R1 outside okay", {30'b0, g_bresp}, 32'h0);
        check_ctrl("R1 outside ignored");
        axi_read((BASE ^ 32'h0001_0000) + 32'h6000);
        check("R1 outside read zero", g_rdata, 32'h0);
        axi_read(BASE + 32'h10);
        check("R11 ram read zero", {g_rdata[29:0], g_rresp}, 32'h0);

        // R11: response held while BREADY low
        s_bready = 1'b0;
        @(negedge clk);
        s_awaddr = BASE + 32'h7000; s_wdata = '0; s_wstrb = 4'hF;
        s_awvalid = 1'b1; s_wvalid = 1'b1;
        @(posedge clk);
        #1 s_awvalid = 1'b0; s_wvalid = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 bvalid held", {31'b0, s_bvalid}, 32'h1);
        s_bready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R11 bvalid dropped", {31'b0, s_bvalid}, 32'h0);

        // random traffic
        for (int i = 0; i < 400; i++) begin
            op = $urandom_range(0, 3);
            d  = $urandom;
            if ($urandom_range(0, 9) != 0) d[20] = 1'b0;
            st = 4'($urandom);
            ev = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'h0;
            case (op)
                0: axi_write(CTRL, d, st, ev);
                1: check_ctrl("R6 R7 random readback");
                2: pulse_ev(4'($urandom));
                default: begin
                    a = BASE + {17'b0, 15'($urandom_range(0, 32'h7FFF)) & 15'h7FFC};
                    if (a[31:2] == CTRL[31:2]) a = a + 4;
                    axi_write(a, d, st, 4'h0);
                    check("R9 random bresp", {30'b0, g_bresp}, {30'b0, exp_bresp(a, st)});
                    check("R9 random we", {31'b0, g_we},
                          {31'b0, (a[14:0] < 15'h6000) && st == 4'hF});
                end
            endcase
        end
        check_ctrl("R2 final");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule